// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block gathers the event pulses of a network controller into one interrupt status register and drives a single interrupt line. Each event sets its own status bit. An enable mask chooses which status bits raise the line. Software clears status bits by writing ones to them. The unit also holds a read-only flag that shows whether the controller is in its stopped (reset) state. Stop and start commands drive this flag, and so does the condition of the receive ring.

Three 8-bit tally counters are also in the block. They count frame alignment errors, CRC errors and frames that were missed. Reading a counter clears it. A counter that reaches 0xFF stays there. When the top bit of any counter goes from 0 to 1, the counter-overflow status bit is raised.

All access goes through a small register bus. A read or a write completes in the cycle it is presented. There is no data stream and no back-pressure, so every pin is a plain level or pulse and there is no valid/ready handshake. Read data is combinational from the current state. The side effect of a read, clearing a counter, takes place at the clock edge that ends the read cycle.

Top module: `irq_event_unit`

## Requirements
- R1: Status bits, by position: 0 receive OK, 1 transmit OK, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counter overflow, 6 remote DMA complete, 7 reset state. An event pulse sets its bit, and a read of the status register (address 0) shows the bit one cycle after the pulse.
- R2: Writing to status address 0 clears each bit 0 to 6 that has a 1 in the write data. Bits written with 0 keep their value.
- R3: If an event arrives in the same cycle as a write that clears its bit, the event wins and the bit stays set.
- R4: The mask register (address 1) stores write-data bits 0 to 6. Bit 7 always reads 0. Mask bit i enables status bit i.
- R5: `irq` is high exactly when some bit in positions 0 to 6 is set in both the status and the mask. Status bit 7 never raises `irq`. After reset `irq` is low.
- R6: The reset-state flag (status bit 7) is 1 after reset. `cmd_stop` sets it and `cmd_start` clears it.
- R7: A ring overwrite event also sets the flag, and `ring_freed` clears it. If a set and a clear arrive in the same cycle, the set wins.
- R8: The reset-state flag is read-only. Writes to the status register leave it unchanged.
- R9: The tally counters are at address 2 (alignment errors), 3 (CRC errors) and 4 (missed frames). Each increment pulse adds one. A read returns the count and then clears it. If an increment arrives in the same cycle as the read, the count after the read is 1.
- R10: A tally counter at 0xFF stays at 0xFF on further increments.
- R11: Status bit 5 is set in the cycle after any tally counter steps from 0x7F to 0x80.
- R12: Addresses 5 to 7 read as 0. Writes to the counter addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx_ok | input | 1 | Pulse: frame received without error |
| ev_tx_ok | input | 1 | Pulse: frame transmitted without error |
| ev_rx_err | input | 1 | Pulse: frame received with an error |
| ev_tx_err | input | 1 | Pulse: transmission failed |
| ev_overwrite | input | 1 | Pulse: receive ring overwritten |
| ev_rdma_done | input | 1 | Pulse: remote DMA finished |
| cmd_stop | input | 1 | Pulse: stop command issued |
| cmd_start | input | 1 | Pulse: start command issued |
| ring_freed | input | 1 | Pulse: one or more frames removed from the ring |
| tally_align | input | 1 | Pulse: count one alignment error |
| tally_crc | input | 1 | Pulse: count one CRC error |
| tally_miss | input | 1 | Pulse: count one missed frame |
| reg_rd | input | 1 | Read strobe (clears the counter being read) |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach is the counter-overflow bit. No event pin drives it directly. It appears only after exactly 128 increment pulses on one counter with no read in between. The bench drives the CRC counter one pulse at a time. It checks that bit 5 is still clear at 127 pulses and set at 128, then keeps pulsing until the counter saturates. Same-cycle collisions are also hard to reach: an event together with its clear, overwrite together with ring freed, and an increment together with a read. The bench reaches these by driving both pins in the same cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int NUM_EV    = 7;
  localparam int NUM_TALLY = 3;

  localparam int B_RX_OK   = 0;
  localparam int B_TX_OK   = 1;
  localparam int B_RX_ERR  = 2;
  localparam int B_TX_ERR  = 3;
  localparam int B_OVW     = 4;
  localparam int B_CNT_OVF = 5;
  localparam int B_RDMA    = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS      = 3'd0,
    A_MASK        = 3'd1,
    A_TALLY_ALIGN = 3'd2,
    A_TALLY_CRC   = 3'd3,
    A_TALLY_MISS  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_tally_ctr.sv
module irq_tally_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         msb_rise
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] nxt;

  always_comb begin
    if (clr)
      nxt = inc ? CNT_ONE : '0;
    else if (inc && count != CNT_MAX)
      nxt = count + CNT_ONE;
    else
      nxt = count;
  end

  assign msb_rise = nxt[W-1] & ~count[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && inc && !clr) |=> (count == CNT_MAX));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count <= CNT_ONE));
endmodule

// File: rtl/irq_reset_flag.sv
module irq_reset_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stop,
  input  logic set_ovw,
  input  logic clr_start,
  input  logic clr_freed,
  output logic flag
);
  logic set_any, clr_any;
  assign set_any = set_stop | set_ovw;
  assign clr_any = clr_start | clr_freed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b1;
    else if (set_any) flag <= 1'b1;
    else if (clr_any) flag <= 1'b0;
  end

  // R6
  stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stop |=> flag);

  // R7
  free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_freed && !set_stop && !set_ovw) |=> !flag);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sts[i] <= 1'b0;
      else if (ev[i])       sts[i] <= 1'b1;
      else if (clr_mask[i]) sts[i] <= 1'b0;
    end

    // R3
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> sts[i]);

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !ev[i]) |=> !sts[i]);
  end
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
  import irq_unit_pkg::*;
#(
  parameter int TALLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_ok,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_err,
  input  logic              ev_tx_err,
  input  logic              ev_overwrite,
  input  logic              ev_rdma_done,
  input  logic              cmd_stop,
  input  logic              cmd_start,
  input  logic              ring_freed,
  input  logic              tally_align,
  input  logic              tally_crc,
  input  logic              tally_miss,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int TALLY_BASE = int'(A_TALLY_ALIGN);

  logic [NUM_EV-1:0]    ev_vec;
  logic [NUM_EV-1:0]    clr_vec;
  logic [NUM_EV-1:0]    sts;
  logic [NUM_EV-1:0]    mask_q;
  logic                 rst_flag;
  logic [NUM_TALLY-1:0] tally_inc;
  logic [NUM_TALLY-1:0] tally_clr;
  logic [NUM_TALLY-1:0] tally_rise;
  logic [TALLY_W-1:0]   tally_cnt [NUM_TALLY];

  assign tally_inc = {tally_miss, tally_crc, tally_align};

  for (genvar k = 0; k < NUM_TALLY; k++) begin : g_tally
    assign tally_clr[k] = reg_rd && (reg_addr == ADDR_W'(TALLY_BASE + k));
    irq_tally_ctr #(.W(TALLY_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (tally_inc[k]),
      .clr      (tally_clr[k]),
      .count    (tally_cnt[k]),
      .msb_rise (tally_rise[k])
    );
  end

  always_comb begin
    ev_vec            = '0;
    ev_vec[B_RX_OK]   = ev_rx_ok;
    ev_vec[B_TX_OK]   = ev_tx_ok;
    ev_vec[B_RX_ERR]  = ev_rx_err;
    ev_vec[B_TX_ERR]  = ev_tx_err;
    ev_vec[B_OVW]     = ev_overwrite;
    ev_vec[B_CNT_OVF] = |tally_rise;
    ev_vec[B_RDMA]    = ev_rdma_done;
  end

  assign clr_vec = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[NUM_EV-1:0] : '0;

  irq_status_reg #(.N(NUM_EV)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_vec),
    .clr_mask (clr_vec),
    .sts      (sts)
  );

  irq_reset_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_stop  (cmd_stop),
    .set_ovw   (ev_overwrite),
    .clr_start (cmd_start),
    .clr_freed (ring_freed),
    .flag      (rst_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mask_q <= '0;
    else if (reg_wr && reg_addr == A_MASK)  mask_q <= reg_wdata[NUM_EV-1:0];
  end

  always_comb begin
    unique case (reg_addr)
      A_STATUS:      reg_rdata = {rst_flag, sts};
      A_MASK:        reg_rdata = {1'b0, mask_q};
      A_TALLY_ALIGN: reg_rdata = DATA_W'(tally_cnt[0]);
      A_TALLY_CRC:   reg_rdata = DATA_W'(tally_cnt[1]);
      A_TALLY_MISS:  reg_rdata = DATA_W'(tally_cnt[2]);
      default:       reg_rdata = '0;
    endcase
  end

  assign irq = |(sts & mask_q);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R11
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tally_rise) |=> sts[B_CNT_OVF]);

  // R8
  flag_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !cmd_stop && !cmd_start && !ev_overwrite && !ring_freed)
      |=> $stable(rst_flag));
endmodule

// File: tb/test_irq_event_unit.sv
module test_irq_event_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx_ok = 0, ev_tx_ok = 0, ev_rx_err = 0, ev_tx_err = 0;
  logic ev_overwrite = 0, ev_rdma_done = 0;
  logic cmd_stop = 0, cmd_start = 0, ring_freed = 0;
  logic tally_align = 0, tally_crc = 0, tally_miss = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_event_unit i_irq_event_unit (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .ev_rx_err(ev_rx_err),
    .ev_tx_err(ev_tx_err), .ev_overwrite(ev_overwrite), .ev_rdma_done(ev_rdma_done),
    .cmd_stop(cmd_stop), .cmd_start(cmd_start), .ring_freed(ring_freed),
    .tally_align(tally_align), .tally_crc(tally_crc), .tally_miss(tally_miss),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  // bit order of p: rx_ok, tx_ok, rx_err, tx_err, overwrite, rdma_done
  task automatic pulse_ev(logic [5:0] p);
    {ev_rdma_done, ev_overwrite, ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = p;
    @(negedge clk);
    {ev_rdma_done, ev_overwrite, ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = '0;
  endtask

  task automatic one_cycle(ref logic sig);
    sig = 1; @(negedge clk); sig = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, exp_sts, m;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R6 R5 R4 R9 reset state
    check("R5 irq after reset", {7'd0, irq}, 8'h00);
    rd(0, d); check("R6 flag after reset", d, 8'h80);
    rd(1, d); check("R4 mask after reset", d, 8'h00);
    for (int a = 2; a < 5; a++) begin rd(3'(a), d); check("R9 tally after reset", d, 8'h00); end
    one_cycle(cmd_start);
    rd(0, d); check("R6 start clears flag", d, 8'h00);

    // R1 R2 R4 R5 R7 sweep of all event combinations
    for (int p = 0; p < 64; p++) begin
      exp_sts = {1'b0, p[5], 1'b0, p[4], p[3], p[2], p[1], p[0]};
      if (p[4]) exp_sts[7] = 1'b1;
      m = 8'((p * 29 + 7) & 8'hFF);
      wr(1, m);
      pulse_ev(6'(p));
      rd(0, d); check("R1 status pattern", d, exp_sts);
      rd(1, d); check("R4 mask readback", d, m & 8'h7F);
      check("R5 irq level", {7'd0, irq}, {7'd0, |(exp_sts[6:0] & m[6:0])});
      wr(0, 8'h00);
      rd(0, d); check("R2 write zero keeps", d, exp_sts);
      if (p[4]) begin
        one_cycle(ring_freed);
        rd(0, d); check("R7 ring freed clears flag", d, exp_sts & 8'h7F);
      end
      wr(0, 8'hFF);
      rd(0, d); check("R2 write ones clears", d, 8'h00);
    end

    // R3 event beats clear
    ev_rx_ok = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'h01;
    @(negedge clk); ev_rx_ok = 0; reg_wr = 0;
    rd(0, d); check("R3 event wins", d, 8'h01);
    wr(0, 8'h01);

    // R8 R5 flag read-only, never interrupts
    wr(1, 8'hFF);
    one_cycle(cmd_stop);
    rd(0, d); check("R6 stop sets flag", d, 8'h80);
    check("R5 flag no irq", {7'd0, irq}, 8'h00);
    wr(0, 8'h80);
    rd(0, d); check("R8 flag write ignored", d, 8'h80);
    one_cycle(cmd_start);
    wr(0, 8'h80);
    rd(0, d); check("R8 flag not set by write", d, 8'h00);

    // R7 set wins over clear
    ev_overwrite = 1; ring_freed = 1; @(negedge clk); ev_overwrite = 0; ring_freed = 0;
    rd(0, d); check("R7 overwrite wins", d, 8'h90);
    one_cycle(ring_freed); wr(0, 8'h7F);
    rd(0, d); check("R7 cleanup", d, 8'h00);

    // R9 counting sweep on alignment counter
    for (int k = 0; k < 20; k++) begin
      for (int j = 0; j < k; j++) one_cycle(tally_align);
      rd(2, d); check("R9 align count", d, 8'(k));
      rd(2, d); check("R9 read clears", d, 8'h00);
    end

    // R9 increment with read
    repeat (3) one_cycle(tally_miss);
    tally_miss = 1; rd(4, d); tally_miss = 0;
    check("R9 read during inc returns old", d, 8'h03);
    rd(4, d); check("R9 inc during read kept", d, 8'h01);

    // R11 R10 overflow and saturation
    wr(1, 8'h20);
    repeat (127) one_cycle(tally_crc);
    rd(0, d); check("R11 no overflow at 7F", d, 8'h00);
    check("R11 irq low at 7F", {7'd0, irq}, 8'h00);
    one_cycle(tally_crc);
    rd(0, d); check("R11 overflow at 80", d, 8'h20);
    check("R11 irq high", {7'd0, irq}, 8'h01);
    repeat (140) one_cycle(tally_crc);
    rd(3, d); check("R10 saturate", d, 8'hFF);
    wr(0, 8'h20);
    check("R5 irq cleared", {7'd0, irq}, 8'h00);

    // R12 map
    for (int a = 5; a < 8; a++) begin rd(3'(a), d); check("R12 unused addr", d, 8'h00); end
    repeat (2) one_cycle(tally_align);
    wr(2, 8'h55);
    rd(2, d); check("R12 counter write ignored", d, 8'h02);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule